// File: doc/BRIEF.md
# Watchdog and Interval Timer with Keyed Restart

This block counts down from a programmable reload value and acts either as a system watchdog or as a periodic interval timer. Software reaches it through a small register-write port. The port has a control register, a reload register and two key registers. Writes to the control and reload registers land in shadow copies. They reach the running logic only when a two-write key sequence restarts the timer. That sequence is 0xA5 to the first key register, then 0x5A to the second key register as the next write.

The count clock comes from one of two sources. The first is the system clock divided by a fixed power of two, and it freezes while the power-down input is high. The second is an enable pulse from a slow oscillator. A 3-bit prescale field then divides the chosen source further before each decrement.

A configuration strap selects watchdog mode, and only the power-on reset can take the block out of it again. In watchdog mode a time-out, a broken key sequence or a control write that is not followed at once by the key sequence raises a one-cycle reset request. Outside watchdog mode, a time-out sets a sticky flag that also drives the interrupt line.

Top module: `wdog_interval_timer`

## Requirements
- R1: After reset the count output is all ones, irq_o and rst_req_o are low, and the counter holds still, because the run bit resets to 0 and watchdog mode is off.
- R2: Register addresses are 0 for control, 1 for reload, 2 for the first key and 3 for the second key. The control fields are: bits [7:5] prescale select, bit 2 run, bit 1 flag, bit 0 source (1 for the oscillator enable, 0 for the system clock divided by 2^CLKDIV_LOG2).
- R3: Control and reload writes change nothing in the running timer until a valid key sequence arrives. That sequence is 0xA5 to address 2, and then 0x5A to address 3 as the next write. At the edge that accepts it, the shadow values become active, the counter loads the shadow reload value and all dividers restart.
- R4: With prescale select P, the counter decrements once every 2^(PRE_BASE+P) source ticks.
- R5: With reload value R, a time-out happens on the (R+1)-th decrement opportunity after a restart, and the counter then reloads the active reload value.
- R6: Outside watchdog mode, a time-out sets the flag and irq_o follows the flag. Writing the control register with bit 1 at 0 clears the flag at once, without waiting for a key sequence. Writing it with bit 1 at 1 leaves the flag unchanged.
- R7: With the system clock source selected, counting pauses for exactly as many cycles as pwr_down is high. With the oscillator source selected, pwr_down has no effect.
- R8: Watchdog mode starts at the first edge where wdt_en_cfg is high, and only rst_n ends it. In watchdog mode the counter runs whatever the run bit says. A time-out then pulses rst_req_o for one cycle and does not set the flag.
- R9: In watchdog mode, rst_req_o pulses for one cycle after any of these writes:
  - a first-key write of a value other than 0xA5;
  - a second-key write that does not directly follow an accepted 0xA5;
  - a second-key write of a value other than 0x5A;
  - any other write after an accepted 0xA5;
  - any write after a control write other than a 0xA5 first-key write.
- R10: Outside watchdog mode, key-sequence errors never assert rst_req_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Write data |
| osc_en | input | 1 | Slow oscillator tick enable |
| pwr_down | input | 1 | CPU power-down indication |
| wdt_en_cfg | input | 1 | Watchdog mode configuration strap |
| cnt_o | output | CNT_W | Current down-counter value |
| irq_o | output | 1 | Interval timer interrupt (flag level) |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The time-out interval is measured in cycles over a sweep of prescale selects and reload values, first with the oscillator held active and then with the divided system clock. This separates an error in the prescale exponent from an off-by-one in the reload count. Runs with a power-down window of known length separate the two clock sources: the system clock path must stretch the interval by exactly that window, and the oscillator path must not stretch it at all. Each key-sequence error case is sent once outside watchdog mode and once inside it. The reset request is sampled after every single write, so a request raised one write too early or too late is caught. A control write followed by a broken key sequence, then a decrement-period measurement, shows whether the shadow copy leaks into the running configuration.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int PRE_W = 3;

  typedef enum logic [1:0] {
    WREG_CTRL   = 2'd0,
    WREG_RELOAD = 2'd1,
    WREG_KEY_A  = 2'd2,
    WREG_KEY_B  = 2'd3
  } wdt_reg_e;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_PEND  = 2'd1,
    SEQ_ARMED = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic             run;
    logic             src_osc;
  } wdt_cfg_t;

  localparam logic [7:0] KEY_A_VAL = 8'hA5;
  localparam logic [7:0] KEY_B_VAL = 8'h5A;

  localparam int CTRL_PRE_LSB  = 5;
  localparam int CTRL_RUN_BIT  = 2;
  localparam int CTRL_FLAG_BIT = 1;
  localparam int CTRL_SRC_BIT  = 0;

  function automatic wdt_cfg_t decode_ctrl(input logic [7:0] d);
    wdt_cfg_t c;
    c.pre     = d[CTRL_PRE_LSB +: PRE_W];
    c.run     = d[CTRL_RUN_BIT];
    c.src_osc = d[CTRL_SRC_BIT];
    return c;
  endfunction

endpackage

// File: rtl/wdt_feed_seq.sv
module wdt_feed_seq
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       feed_o,
  output logic       viol_o
);

  seq_state_e state_q, state_d;
  logic       bad;

  always_comb begin
    state_d = state_q;
    feed_o  = 1'b0;
    bad     = 1'b0;
    if (wr_en) begin
      case (wdt_reg_e'(wr_addr))
        WREG_CTRL: begin
          bad     = (state_q != SEQ_IDLE);
          state_d = SEQ_PEND;
        end
        WREG_RELOAD: begin
          bad     = (state_q != SEQ_IDLE);
          state_d = SEQ_IDLE;
        end
        WREG_KEY_A: begin
          if ((wr_data == KEY_A_VAL) && (state_q != SEQ_ARMED)) begin
            state_d = SEQ_ARMED;
          end else begin
            bad     = 1'b1;
            state_d = SEQ_IDLE;
          end
        end
        WREG_KEY_B: begin
          if ((wr_data == KEY_B_VAL) && (state_q == SEQ_ARMED)) feed_o = 1'b1;
          else                                                    bad    = 1'b1;
          state_d = SEQ_IDLE;
        end
        default: state_d = SEQ_IDLE;
      endcase
    end
  end

  assign viol_o = bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  // R9: a restart and a violation never come from the same write
  assert_feed_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(feed_o && viol_o));

endmodule

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen
  import wdt_pkg::*;
#(
  parameter int PRE_BASE    = 5,
  parameter int CLKDIV_LOG2 = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             src_osc,
  input  logic             osc_en,
  input  logic             pwr_down,
  input  logic [PRE_W-1:0] pre,
  output logic             tick_o
);

  localparam int MAX_EXP = PRE_BASE + (1 << PRE_W) - 1;
  localparam int PSC_W   = (MAX_EXP > 0) ? MAX_EXP : 1;

  logic             sys_full;
  logic             src_tick;
  logic [PSC_W-1:0] psc_q, psc_d;
  logic [PSC_W:0]   one_sh;
  logic [PSC_W:0]   mask_full;
  logic [PSC_W-1:0] mask;

  generate
    if (CLKDIV_LOG2 > 0) begin : g_div
      logic [CLKDIV_LOG2-1:0] div_q, div_d;
      logic                   div_adv;

      assign div_adv  = run && !src_osc && !pwr_down;
      assign sys_full = &div_q;

      always_comb begin
        div_d = div_q;
        if (restart)      div_d = '0;
        else if (div_adv) div_d = div_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
      end

      // R7: the system clock divider holds while powered down
      assert_div_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_down && !src_osc && !restart) |=> $stable(div_q));
    end else begin : g_nodiv
      assign sys_full = 1'b1;
    end
  endgenerate

  assign src_tick  = run && (src_osc ? osc_en : (!pwr_down && sys_full));
  assign one_sh    = {{PSC_W{1'b0}}, 1'b1} << (PRE_BASE + int'(pre));
  assign mask_full = one_sh - 1'b1;
  assign mask      = mask_full[PSC_W-1:0];
  assign tick_o    = src_tick && !restart && ((psc_q & mask) == mask);

  always_comb begin
    psc_d = psc_q;
    if (restart)       psc_d = '0;
    else if (src_tick) psc_d = psc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) psc_q <= '0;
    else        psc_q <= psc_d;
  end

  // R4: the prescaler advances only on source ticks
  assert_psc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !src_tick) |=> $stable(psc_q));

endmodule

// File: rtl/wdt_down_cnt.sv
module wdt_down_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] wrap_val,
  input  logic             wd_mode,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt_o,
  output logic             timeout_o,
  output logic             flag_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flag_q, flag_d;

  assign timeout_o = tick && !restart && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (restart)        cnt_d = load_val;
    else if (timeout_o) cnt_d = wrap_val;
    else if (tick)      cnt_d = cnt_q - 1'b1;
  end

  always_comb begin
    flag_d = flag_q;
    if (flag_clr)                   flag_d = 1'b0;
    else if (timeout_o && !wd_mode) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '1;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;

  // R3: a restart loads the shadow reload value
  assert_restart_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == $past(load_val)));

  // R4: a tick on a nonzero count is a single decrement
  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R8: the flag never rises in watchdog mode
  assert_flag_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> !$past(wd_mode));

endmodule

// File: rtl/wdog_interval_timer.sv
module wdog_interval_timer
  import wdt_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PRE_BASE    = 5,
  parameter int CLKDIV_LOG2 = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             osc_en,
  input  logic             pwr_down,
  input  logic             wdt_en_cfg,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o,
  output logic             rst_req_o
);

  localparam int RLD_W = (CNT_W < 8) ? CNT_W : 8;

  logic [1:0]       rst_sync_q;
  logic             rst_ni;
  wdt_cfg_t         sh_cfg_q, sh_cfg_d, act_cfg_q, act_cfg_d;
  logic [CNT_W-1:0] sh_rld_q, sh_rld_d, act_rld_q, act_rld_d;
  logic             wd_mode_q, wd_mode_d;
  logic             rst_req_q, rst_req_d;
  logic             feed, viol, tick, timeout, run_eff, flag_clr;
  logic             wr_ctrl, wr_rld;
  logic             unused_bits;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  assign wr_ctrl     = wr_en && (wdt_reg_e'(wr_addr) == WREG_CTRL);
  assign wr_rld      = wr_en && (wdt_reg_e'(wr_addr) == WREG_RELOAD);
  assign flag_clr    = wr_ctrl && !wr_data[CTRL_FLAG_BIT];
  assign unused_bits = ^wr_data;

  wdt_feed_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_ni),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .feed_o  (feed),
    .viol_o  (viol)
  );

  always_comb begin
    sh_cfg_d  = sh_cfg_q;
    sh_rld_d  = sh_rld_q;
    act_cfg_d = act_cfg_q;
    act_rld_d = act_rld_q;
    if (wr_ctrl) sh_cfg_d = decode_ctrl(wr_data);
    if (wr_rld) begin
      sh_rld_d            = '0;
      sh_rld_d[RLD_W-1:0] = wr_data[RLD_W-1:0];
    end
    if (feed) begin
      act_cfg_d = sh_cfg_q;
      act_rld_d = sh_rld_q;
    end
  end

  assign wd_mode_d = wd_mode_q || wdt_en_cfg;
  assign run_eff   = wd_mode_q || act_cfg_q.run;
  assign rst_req_d = wd_mode_q && (timeout || viol);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_cfg_q  <= '0;
      act_cfg_q <= '0;
      sh_rld_q  <= '1;
      act_rld_q <= '1;
      wd_mode_q <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      sh_cfg_q  <= sh_cfg_d;
      act_cfg_q <= act_cfg_d;
      sh_rld_q  <= sh_rld_d;
      act_rld_q <= act_rld_d;
      wd_mode_q <= wd_mode_d;
      rst_req_q <= rst_req_d;
    end
  end

  wdt_tick_gen #(
    .PRE_BASE    (PRE_BASE),
    .CLKDIV_LOG2 (CLKDIV_LOG2)
  ) u_tick (
    .clk      (clk),
    .rst_n    (rst_ni),
    .run      (run_eff),
    .restart  (feed),
    .src_osc  (act_cfg_q.src_osc),
    .osc_en   (osc_en),
    .pwr_down (pwr_down),
    .pre      (act_cfg_q.pre),
    .tick_o   (tick)
  );

  wdt_down_cnt #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_ni),
    .tick      (tick),
    .restart   (feed),
    .load_val  (sh_rld_q),
    .wrap_val  (act_rld_q),
    .wd_mode   (wd_mode_q),
    .flag_clr  (flag_clr),
    .cnt_o     (cnt_o),
    .timeout_o (timeout),
    .flag_o    (irq_o)
  );

  assign rst_req_o = rst_req_q;

  // R8: watchdog mode is sticky
  assert_mode_sticky_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    wd_mode_q |=> wd_mode_q);

  // R10: no reset request outside watchdog mode
  assert_req_mode_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    rst_req_q |-> wd_mode_q);

  // R3: active configuration changes only through a restart
  assert_shadow_hold_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    !feed |=> $stable(act_cfg_q) && $stable(act_rld_q));

  // R3: a restart copies the shadow configuration
  assert_shadow_copy_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    feed |=> (act_cfg_q == $past(sh_cfg_q)));

endmodule

// File: tb/wdog_interval_timer_bench.sv
module wdog_interval_timer_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic       osc_en;
  logic       pwr_down;
  logic       wdt_en_cfg;
  logic [7:0] cnt_o;
  logic       irq_o;
  logic       rst_req_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  wdog_interval_timer #(
    .CNT_W       (8),
    .PRE_BASE    (0),
    .CLKDIV_LOG2 (2)
  ) u_wdog_interval_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .osc_en     (osc_en),
    .pwr_down   (pwr_down),
    .wdt_en_cfg (wdt_en_cfg),
    .cnt_o      (cnt_o),
    .irq_o      (irq_o),
    .rst_req_o  (rst_req_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic feed();
    wr(2'd2, 8'hA5);
    wr(2'd3, 8'h5A);
  endtask

  // program in timer mode from a stopped, flag-clear state
  task automatic restart(input int p, input int r, input bit osc);
    wr(2'd0, 8'h00);
    feed();
    wr(2'd0, 8'h00);
    wr(2'd1, 8'(r));
    wr(2'd0, 8'((p << 5) | 4 | (osc ? 1 : 0)));
    feed();
  endtask

  task automatic wait_sig(input bit use_rst, input int limit, input int pd_on,
                          input int pd_off, output int n);
    n = 0;
    while (n < limit) begin
      @(posedge clk);
      n++;
      #1;
      if (n == pd_on)  pwr_down = 1'b1;
      if (n == pd_off) pwr_down = 1'b0;
      if (use_rst ? rst_req_o : irq_o) break;
    end
  endtask

  task automatic decr_period(output int n);
    logic [7:0] v;
    n = 0;
    @(posedge clk); #1 v = cnt_o;
    while (cnt_o == v && n < 1000) begin @(posedge clk); #1 n++; end
    v = cnt_o; n = 0;
    while (n < 1000) begin
      @(posedge clk); #1 n++;
      if (cnt_o != v) break;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n, exp;
    int rvals[3] = '{0, 2, 5};
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = 2'd0; wr_data = 8'h00;
    osc_en = 1'b1; pwr_down = 1'b0; wdt_en_cfg = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(cnt_o == 8'hFF, "R1 count after reset", cnt_o, 255);
    check(irq_o == 1'b0, "R1 irq after reset", irq_o, 0);
    check(rst_req_o == 1'b0, "R1 rst_req after reset", rst_req_o, 0);
    repeat (20) @(posedge clk);
    #1 check(cnt_o == 8'hFF, "R1 counter idle", cnt_o, 255);

    // R4 R5 R6 oscillator source sweep, R2 field positions
    for (int p = 0; p < 4; p++) begin
      foreach (rvals[i]) begin
        restart(p, rvals[i], 1'b1);
        check(cnt_o == 8'(rvals[i]), "R3 load on feed", cnt_o, rvals[i]);
        exp = (rvals[i] + 1) << p;
        wait_sig(1'b0, 2000, -1, -1, n);
        check(n == exp, "R5 osc interval", n, exp);
      end
    end
    restart(7, 1, 1'b1);
    wait_sig(1'b0, 2000, -1, -1, n);
    check(n == 256, "R4 max prescale", n, 256);

    // R7 system clock source
    for (int p = 0; p < 2; p++) begin
      restart(p, 2, 1'b0);
      exp = 3 * 4 << p;
      wait_sig(1'b0, 2000, -1, -1, n);
      check(n == exp, "R7 sysclk interval", n, exp);
    end
    restart(0, 3, 1'b0);
    wait_sig(1'b0, 2000, 3, 13, n);
    check(n == 26, "R7 power-down stretch", n, 26);
    restart(0, 3, 1'b1);
    wait_sig(1'b0, 2000, 3, 13, n);
    check(n == 4, "R7 oscillator ignores power-down", n, 4);
    pwr_down = 1'b0;

    // R6 flag clear semantics
    restart(3, 5, 1'b1);
    wait_sig(1'b0, 2000, -1, -1, n);
    check(irq_o == 1'b1, "R6 flag set", irq_o, 1);
    wr(2'd0, 8'h67);
    check(irq_o == 1'b1, "R6 write 1 keeps flag", irq_o, 1);
    wr(2'd0, 8'h65);
    check(irq_o == 1'b0, "R6 write 0 clears flag", irq_o, 0);

    // R3 shadow isolation, R10 no reset in timer mode
    restart(0, 7, 1'b1);
    wr(2'd0, 8'h65);
    wr(2'd2, 8'h00);
    check(rst_req_o == 1'b0, "R10 broken key in timer mode", rst_req_o, 0);
    wr(2'd3, 8'h5A);
    check(rst_req_o == 1'b0, "R10 lone second key", rst_req_o, 0);
    decr_period(n);
    check(n == 1, "R3 shadow not active", n, 1);
    feed();
    decr_period(n);
    check(n == 8, "R3 shadow active after feed", n, 8);

    // R8 enter watchdog mode, strap released
    restart(7, 200, 1'b1);
    @(negedge clk) wdt_en_cfg = 1'b1;
    @(negedge clk) wdt_en_cfg = 1'b0;
    wr(2'd1, 8'd9);
    wr(2'd0, 8'h01);
    feed();
    wait_sig(1'b1, 2000, -1, -1, n);
    check(n == 10, "R8 timeout reset ignores run bit", n, 10);
    @(posedge clk); #1;
    check(rst_req_o == 1'b0, "R8 reset is one cycle", rst_req_o, 0);
    check(irq_o == 1'b0, "R8 no flag in watchdog mode", irq_o, 0);
    wait_sig(1'b1, 2000, -1, -1, n);
    check(n == 9, "R8 periodic after reload", n, 9);

    // R9 key violations, long period
    wr(2'd1, 8'd200);
    wr(2'd0, 8'hE1);
    feed();
    check(rst_req_o == 1'b0, "R9 valid ctrl+feed no reset", rst_req_o, 0);
    wr(2'd2, 8'h00);
    check(rst_req_o == 1'b1, "R9 bad first key", rst_req_o, 1);
    @(posedge clk); #1;
    check(rst_req_o == 1'b0, "R9 pulse ends", rst_req_o, 0);
    wr(2'd3, 8'h5A);
    check(rst_req_o == 1'b1, "R9 second key unarmed", rst_req_o, 1);
    wr(2'd2, 8'hA5);
    check(rst_req_o == 1'b0, "R9 accepted first key", rst_req_o, 0);
    wr(2'd1, 8'd200);
    check(rst_req_o == 1'b1, "R9 write after armed key", rst_req_o, 1);
    wr(2'd0, 8'hE1);
    check(rst_req_o == 1'b0, "R9 ctrl write alone", rst_req_o, 0);
    wr(2'd1, 8'd200);
    check(rst_req_o == 1'b1, "R9 ctrl not followed by key", rst_req_o, 1);
    wr(2'd2, 8'hA5);
    wr(2'd3, 8'h55);
    check(rst_req_o == 1'b1, "R9 wrong second key", rst_req_o, 1);
    feed();
    check(rst_req_o == 1'b0, "R9 clean feed", rst_req_o, 0);
    check(cnt_o == 8'd200, "R3 feed reload in watchdog mode", cnt_o, 200);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule